// File: doc/BRIEF.md
# Address Bus Parity and Hold Unit

This unit is the address half of a 32-bit processor's external bus interface. When the core issues a bus cycle, the unit registers the address, which is double-word aligned (bits 31 down to 3), together with the byte enables. It also registers an even-parity bit over that address. All three are presented in the same clock. An active-low real-mode mask input can clear physical address bit 20 when the address is captured.

An external agent can take the address lines with a hold input. One clock after hold is sampled high, the shared enable for the address and parity drivers drops. One clock after hold is sampled low, the enable returns. The byte enables and the capture of new cycles continue while hold is high, so transfers already in flight still finish.

During a snoop, the agent drives an address on bits 31 down to 5 and a parity bit, and pulses an active-low strobe. The unit checks the snooped bits for even parity. When the check fails, it pulses an active-low error output for exactly one clock. A three-register chain of one-bit error flags gives every strobe its own result, including strobes on consecutive clocks.

Top module: `addr_bus_unit`

## Requirements
- R1: While synchronous reset is high, and after it, until the next event: `par_chk_n` is 1, `addr_oe` is 0, and `bus_addr`, `bus_be` and `bus_par` are 0.
- R2: When `cyc_valid` is 1 at a rising edge, `bus_addr` and `bus_be` take `cyc_addr` and `cyc_be` after that edge. Otherwise they hold their values.
- R3: `bus_par` is such that `bus_addr[31:3]` and `bus_par` together hold an even number of ones, in the same clock as the address.
- R4: With `a20_mask_n` at 0 when a cycle is captured, `bus_addr[20]` is 0. With `a20_mask_n` at 1, bit 20 passes through unchanged. Other bits are never affected.
- R5: `addr_oe` becomes 0 after the first edge at which `hold` is sampled 1, and becomes 1 after the first edge at which it is sampled 0. `bus_be` and cycle capture keep working during hold.
- R6: A snoop with `inq_strobe_n` at 0 at edge n, whose `inq_addr[31:5]` and `inq_par` hold an odd number of ones, drives `par_chk_n` to 0 after edge n+2.
- R7: Each parity error gives a `par_chk_n` low of exactly one clock. A snoop with correct parity gives no pulse.
- R8: Snoop strobes on consecutive edges each produce their own independent result two clocks later.
- R9: With `inq_strobe_n` at 1, `inq_addr` and `inq_par` have no effect on `par_chk_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_valid | input | 1 | Core issues a bus cycle this clock |
| cyc_addr | input | 29 | Core address bits 31..3 |
| cyc_be | input | 8 | Core byte enables |
| a20_mask_n | input | 1 | Active-low mask for address bit 20 |
| hold | input | 1 | External request to release address and parity |
| inq_strobe_n | input | 1 | Active-low snoop strobe |
| inq_addr | input | 27 | Snooped address bits 31..5 |
| inq_par | input | 1 | Snooped parity bit |
| bus_addr | output | 29 | Driven address bits 31..3 |
| bus_be | output | 8 | Driven byte enables |
| bus_par | output | 1 | Even parity over `bus_addr` |
| addr_oe | output | 1 | Output enable for address and parity drivers |
| par_chk_n | output | 1 | Active-low snoop parity error pulse |

## Verification
Address, byte enables and parity are due one edge after capture, and the enable is due one edge after `hold` is sampled. The error pulse is due after the third edge, counting the edge that sampled the strobe. The bench drives inputs at the falling edge and updates a behavioural model at each rising edge. It compares at the following falling edge. The model delays error flags through a queue primed with two zeros, so every expected pulse lands on the third edge and not the second or the fourth.

// File: rtl/addr_bus_unit.sv
module addr_bus_unit #(
  parameter int ADDR_HI  = 31,
  parameter int ADDR_LO  = 3,
  parameter int INQ_LO   = 5,
  parameter int MASK_BIT = 20,
  parameter int BE_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cyc_valid,
  input  logic [ADDR_HI:ADDR_LO] cyc_addr,
  input  logic [BE_W-1:0]      cyc_be,
  input  logic                 a20_mask_n,
  input  logic                 hold,
  input  logic                 inq_strobe_n,
  input  logic [ADDR_HI:INQ_LO] inq_addr,
  input  logic                 inq_par,
  output logic [ADDR_HI:ADDR_LO] bus_addr,
  output logic [BE_W-1:0]      bus_be,
  output logic                 bus_par,
  output logic                 addr_oe,
  output logic                 par_chk_n
);
  logic [ADDR_HI:ADDR_LO] masked;
  logic                   inq_err;
  logic                   err_s1, err_s2, err_q;

  always_comb begin
    masked = cyc_addr;
    if (!a20_mask_n) masked[MASK_BIT] = 1'b0;
  end

  assign inq_err = !inq_strobe_n && (^{inq_addr, inq_par});

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_be   <= '0;
      bus_par  <= 1'b0;
      addr_oe  <= 1'b0;
    end else begin
      addr_oe <= !hold;
      if (cyc_valid) begin
        bus_addr <= masked;
        bus_be   <= cyc_be;
        bus_par  <= ^masked;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_s1 <= 1'b0;
      err_s2 <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_s1 <= inq_err;
      err_s2 <= err_s1;
      err_q  <= err_s2;
    end
  end

  assign par_chk_n = ~err_q;
endmodule

module addr_bus_unit_chk #(
  parameter int ADDR_HI  = 31,
  parameter int ADDR_LO  = 3,
  parameter int MASK_BIT = 20,
  parameter int BE_W     = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cyc_valid,
  input logic [BE_W-1:0]        cyc_be,
  input logic                   a20_mask_n,
  input logic                   hold,
  input logic                   inq_strobe_n,
  input logic [ADDR_HI:ADDR_LO] bus_addr,
  input logic [BE_W-1:0]        bus_be,
  input logic                   bus_par,
  input logic                   addr_oe,
  input logic                   par_chk_n
);
  assert_be_capture_R2: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |=> bus_be == $past(cyc_be));
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cyc_valid |=> $stable(bus_addr));
  assert_even_parity_R3: assert property (@(posedge clk) disable iff (rst)
    (^{bus_addr, bus_par}) == 1'b0);
  assert_a20_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && !a20_mask_n) |=> bus_addr[MASK_BIT] == 1'b0);
  assert_hold_off_R5: assert property (@(posedge clk) disable iff (rst)
    hold |=> !addr_oe);
  assert_hold_on_R5: assert property (@(posedge clk) disable iff (rst)
    !hold |=> addr_oe);
  assert_pulse_origin_R6: assert property (@(posedge clk) disable iff (rst)
    !par_chk_n |-> $past(inq_strobe_n, 3) == 1'b0);
endmodule

bind addr_bus_unit addr_bus_unit_chk #(
  .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .MASK_BIT(MASK_BIT), .BE_W(BE_W)
) u_chk (
  .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_be(cyc_be),
  .a20_mask_n(a20_mask_n), .hold(hold), .inq_strobe_n(inq_strobe_n),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_par(bus_par),
  .addr_oe(addr_oe), .par_chk_n(par_chk_n)
);

// File: tb/tb_addr_bus_unit.sv
`timescale 1ns/1ps
module tb_addr_bus_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_valid = 1'b0;
  logic [31:3] cyc_addr = '0;
  logic [7:0] cyc_be = '0;
  logic a20_mask_n = 1'b1;
  logic hold = 1'b0;
  logic inq_strobe_n = 1'b1;
  logic [31:5] inq_addr = '0;
  logic inq_par = 1'b0;
  logic [31:3] bus_addr;
  logic [7:0] bus_be;
  logic bus_par, addr_oe, par_chk_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:3] m_addr;
  logic [7:0] m_be;
  logic m_par, m_oe, m_chk_n;
  bit errq[$];

  always #4 clk = ~clk;

  addr_bus_unit dut (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .cyc_be(cyc_be), .a20_mask_n(a20_mask_n), .hold(hold),
    .inq_strobe_n(inq_strobe_n), .inq_addr(inq_addr), .inq_par(inq_par),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_par(bus_par),
    .addr_oe(addr_oe), .par_chk_n(par_chk_n)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic update_model();
    if (rst) begin
      m_addr = '0; m_be = '0; m_par = 0; m_oe = 0; m_chk_n = 1;
      errq.delete(); errq.push_back(0); errq.push_back(0);
    end else begin
      bit e;
      m_oe = !hold;
      if (cyc_valid) begin
        m_addr = cyc_addr;
        if (!a20_mask_n) m_addr[20] = 1'b0;
        m_be = cyc_be;
        m_par = ($countones(m_addr) % 2) == 1;
      end
      e = !inq_strobe_n && (($countones(inq_addr) + inq_par) % 2 == 1);
      errq.push_back(e);
      m_chk_n = !errq.pop_front();
    end
  endtask

  task automatic compare_all();
    check("R2 bus_addr", bus_addr, m_addr);
    check("R2 bus_be", bus_be, m_be);
    check("R3 bus_par", bus_par, m_par);
    check("R5 addr_oe", addr_oe, m_oe);
    check("R6 par_chk_n", par_chk_n, m_chk_n);
  endtask

  task automatic tick();
    @(posedge clk);
    update_model();
    @(negedge clk);
    compare_all();
  endtask

  task automatic snoop(input logic [31:5] a, input bit bad);
    inq_strobe_n = 0;
    inq_addr = a;
    inq_par = (($countones(a) % 2) == 1) ^ bad;
  endtask

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all R actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    check("R1 par_chk_n", par_chk_n, 1);
    check("R1 addr_oe", addr_oe, 0);
    check("R1 bus_addr", bus_addr, 0);
    check("R1 bus_par", bus_par, 0);
    rst = 0;
    tick();

    cyc_valid = 1; cyc_addr = '1; cyc_be = 8'hF0; a20_mask_n = 0;
    tick();
    check("R4 bit20 cleared", bus_addr[20], 0);
    check("R4 bit21 kept", bus_addr[21], 1);
    a20_mask_n = 1; cyc_addr = 29'h0002_0001;
    tick();
    check("R4 bit20 passes", bus_addr[20], 1);
    cyc_valid = 0; cyc_addr = '0;
    tick();
    check("R2 holds without cycle", bus_addr, 29'h0002_0001);

    hold = 1;
    tick();
    check("R5 oe off after hold", addr_oe, 0);
    cyc_valid = 1; cyc_addr = 29'h0ABC_DEF0; cyc_be = 8'h3C;
    tick();
    check("R5 be during hold", bus_be, 8'h3C);
    cyc_valid = 0; hold = 0;
    tick();
    check("R5 oe back", addr_oe, 1);

    snoop(27'h123_4567, 1);
    tick(); inq_strobe_n = 1; inq_addr = '0; inq_par = 0;
    check("R6 no early pulse e1", par_chk_n, 1);
    tick();
    check("R6 no early pulse e2", par_chk_n, 1);
    tick();
    check("R6 pulse on third edge", par_chk_n, 0);
    tick();
    check("R7 pulse one clock", par_chk_n, 1);

    snoop(27'h7FF_0001, 0);
    tick(); inq_strobe_n = 1;
    tick(); tick();
    check("R7 good parity no pulse", par_chk_n, 1);
    tick();

    snoop(27'h000_0011, 1); tick();
    snoop(27'h000_0011, 0); tick();
    snoop(27'h555_5555, 1); tick();
    inq_strobe_n = 1;
    check("R8 first pulse", par_chk_n, 0);
    tick();
    check("R8 gap for good snoop", par_chk_n, 1);
    tick();
    check("R8 third pulse", par_chk_n, 0);
    tick();

    inq_strobe_n = 1; inq_addr = 27'h000_0001; inq_par = 0;
    tick(); tick(); tick();
    check("R9 ignored without strobe", par_chk_n, 1);
    tick();

    for (int i = 0; i < 400; i++) begin
      cyc_valid = $urandom_range(0, 1);
      cyc_addr = 29'($urandom);
      cyc_be = 8'($urandom);
      a20_mask_n = $urandom_range(0, 3) != 0;
      hold = $urandom_range(0, 3) == 0;
      inq_strobe_n = $urandom_range(0, 1);
      inq_addr = 27'($urandom);
      inq_par = $urandom_range(0, 1);
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule